// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital side of a 10-bit successive-approximation converter. It divides the system clock by a selectable ratio to produce ADC clock ticks. It then runs each conversion as a fixed sequence of ADC clock cycles. At the start of a conversion it captures the input-select code. Half an ADC clock into the sampling cycle it pulses the sample-and-hold strobe. After that it resolves one result bit per ADC clock, from the most significant bit down, using an external comparator. When the sequence ends it stores the result, raises the done flag and drops the start bit.

The whole design runs in the system clock domain. The ADC clock exists only as rise and fall tick enables. Software raises `start` for one cycle to request a conversion. `busy` reflects the internal start bit. The stored result has no back-pressure. The done flag serves as its valid indication. A later completion overwrites the result whether or not the flag was cleared. The first conversion after enable runs a longer sequence with a later sample point, so that the analog front end has time to settle.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `done_flag`, `sh_strobe`, `dac_code`, `result` and `mux_q` are all zero.
- R2: The ADC clock period is N system clocks. N is 2 for `psel` 0 and 1, and 2^psel for `psel` 2 to 7. While `en` is low the divider counter is held at zero. When `en` and `start` are first seen together, that conversion completes exactly 26N-1 system clocks later.
- R3: A `start` pulse sets the start bit only while `en` is high. The conversion then begins on the next ADC rising tick. A `start` pulse while `en` is low has no effect.
- R4: A normal conversion lasts 13 ADC clocks. The done flag rises between 13N+1 and 14N system clocks after the edge that samples `start`.
- R5: The first conversion after `en` rises lasts 25 ADC clocks.
- R6: `sh_strobe` is a single system-clock pulse, once per conversion. It sits 1.5 ADC clocks after the start of a normal conversion and 13.5 ADC clocks after the start of a first conversion. It therefore leads the done flag by exactly 11.5N system clocks.
- R7: `mux_q` takes `mux_sel` at the edge where a conversion begins. It holds that value through the conversion, whatever `mux_sel` does later.
- R8: N/2 system clocks after the strobe, `dac_code` is 10'h200, the trial of the MSB. At each following ADC rising tick the trial bit is kept if `cmp_in` is 1 and dropped if it is 0, and the next lower bit is tried. With a comparator that reports `dac_code <= v`, the result equals v.
- R9: At completion, `result` is written, `done_flag` rises and `busy` falls on the same edge.
- R10: `done_flag` stays set until a `flag_clr` pulse clears it. A completion in the same cycle as `flag_clr` wins.
- R11: Lowering `en` aborts a conversion in progress. `busy` drops, no completion follows, and the next conversion runs the 25-cycle sequence.
- R12: A `start` pulse while a conversion is pending or running is ignored. Exactly one completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Converter enable; low holds the divider and aborts |
| start | input | 1 | One-cycle conversion request |
| psel | input | 3 | Divide-ratio select |
| mux_sel | input | 4 | Input channel and reference select |
| cmp_in | input | 1 | Comparator decision, 1 keeps the trial bit |
| flag_clr | input | 1 | Write-one-to-clear pulse for the done flag |
| dac_code | output | 10 | Trial code for the DAC |
| sh_strobe | output | 1 | Sample-and-hold pulse |
| mux_q | output | 4 | Select code latched for the running conversion |
| busy | output | 1 | Start bit: conversion pending or running |
| result | output | 10 | Last completed conversion result |
| done_flag | output | 1 | Conversion complete flag |

## Verification
The hardest behaviour to pin down from the ports is the exact cycle count of the long first conversion, because the divider phase is normally unknown to the outside. The bench holds `en` low and then raises `en` and `start` in the same cycle. This makes the divider phase known, so the 25-cycle sequence and its divider restart can be checked to the exact system clock. The same exact check runs again after an abort in the middle of a conversion, to show that the long sequence is re-armed. The comparator is modelled in the bench as a comparison of `dac_code` against a chosen input value, so each result has a known expected code. The bench also toggles `mux_sel` after the strobe, to show that the latched select does not follow it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned SAR_BITS   = 10;
  localparam int unsigned DIV_SEL_W  = 3;
  localparam int unsigned SEL_CODE_W = 4;
  // sampling completes at the end of this ADC cycle of a normal conversion
  localparam int unsigned SAMPLE_CYC = 2;
  // extra ADC cycles inserted ahead of sampling on the first conversion
  localparam int unsigned WARMUP_CYC = 12;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_CONV = 1'b1
  } conv_phase_t;

endpackage

// File: rtl/adc_presc.sv
module adc_presc #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] psel,
  output logic             rise_tick,
  output logic             fall_tick
);

  // widest ratio is 2^(2^SEL_W - 1)
  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wrap_mask;
  logic [CNT_W-1:0] half_mask;
  logic [SEL_W-1:0] log_div;

  // codes 0 and 1 both divide by two
  assign log_div = (psel == '0) ? SEL_W'(1) : psel;

  genvar g;
  generate
    for (g = 0; g < CNT_W; g++) begin : g_mask
      assign wrap_mask[g] = (32'(log_div) > g);
    end
  endgenerate

  assign half_mask = wrap_mask >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!en)  cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assign rise_tick = en && ((cnt_q & wrap_mask) == wrap_mask);
  assign fall_tick = en && ((cnt_q & wrap_mask) == half_mask);

  AST_PRESC_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (cnt_q == '0)); // R2

  AST_TICKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick)); // R2

endmodule

// File: rtl/adc_sar.sv
module adc_sar #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             step,
  input  logic             cmp_in,
  output logic [WIDTH-1:0] code
);

  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] code_q;
  logic [WIDTH-1:0] ptr_q;
  logic [WIDTH-1:0] code_d;

  always_comb begin
    code_d = cmp_in ? code_q : (code_q & ~ptr_q);
    code_d = code_d | (ptr_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ptr_q  <= '0;
    end else if (clr) begin
      code_q <= '0;
      ptr_q  <= '0;
    end else if (load) begin
      code_q <= TOP_BIT;
      ptr_q  <= TOP_BIT;
    end else if (step && (ptr_q != '0)) begin
      code_q <= code_d;
      ptr_q  <= ptr_q >> 1;
    end
  end

  assign code = code_q;

  AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr_q)); // R8

  AST_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !load && cmp_in && (ptr_q != '0)) |=> ((code_q & $past(ptr_q)) != '0)); // R8

  AST_BIT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !load && !cmp_in && (ptr_q != '0)) |=> ((code_q & $past(ptr_q)) == '0)); // R8

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned NBITS     = 10,
  parameter int unsigned SAMP_AT   = 2,
  parameter int unsigned WARMUP    = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rise_tick,
  input  logic fall_tick,
  input  logic start_bit,
  output logic begin_p,
  output logic samp_p,
  output logic load_p,
  output logic step_p,
  output logic done_p,
  output logic conv_act
);

  localparam int unsigned SHORT_LEN = SAMP_AT + NBITS + 1;
  localparam int unsigned LONG_LEN  = SHORT_LEN + WARMUP;
  localparam int unsigned CYC_W     = $clog2(LONG_LEN + 1);

  conv_phase_t      ph_q;
  logic [CYC_W-1:0] cyc_q;
  logic             long_q;
  logic             arm_long_q;

  logic [CYC_W-1:0] shift_c;
  logic [CYC_W-1:0] samp_c;
  logic [CYC_W-1:0] first_step_c;
  logic [CYC_W-1:0] last_step_c;
  logic [CYC_W-1:0] len_c;

  always_comb begin
    shift_c      = long_q ? CYC_W'(WARMUP) : '0;
    samp_c       = shift_c + CYC_W'(SAMP_AT);
    first_step_c = samp_c + 1'b1;
    last_step_c  = samp_c + CYC_W'(NBITS);
    len_c        = shift_c + CYC_W'(SHORT_LEN);
  end

  assign conv_act = (ph_q == PH_CONV);

  assign begin_p = en && rise_tick && !conv_act && start_bit;
  assign load_p  = en && rise_tick && conv_act && (cyc_q == samp_c);
  assign step_p  = en && rise_tick && conv_act &&
                   (cyc_q >= first_step_c) && (cyc_q <= last_step_c);
  assign done_p  = en && rise_tick && conv_act && (cyc_q == len_c);
  assign samp_p  = en && fall_tick && conv_act && (cyc_q == samp_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      cyc_q      <= '0;
      long_q     <= 1'b0;
      arm_long_q <= 1'b1;
    end else if (!en) begin
      ph_q       <= PH_IDLE;
      cyc_q      <= '0;
      arm_long_q <= 1'b1;
    end else if (begin_p) begin
      ph_q       <= PH_CONV;
      cyc_q      <= CYC_W'(1);
      long_q     <= arm_long_q;
      arm_long_q <= 1'b0;
    end else if (done_p) begin
      ph_q       <= PH_IDLE;
      cyc_q      <= '0;
    end else if (conv_act && rise_tick) begin
      cyc_q      <= cyc_q + 1'b1;
    end
  end

  AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    conv_act |-> ((cyc_q != '0) && (cyc_q <= CYC_W'(LONG_LEN)))); // R4

  AST_SAMPLE_BEFORE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    samp_p |-> !step_p); // R6

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = SAR_BITS,
  parameter int unsigned PSEL_W = DIV_SEL_W,
  parameter int unsigned MUX_W  = SEL_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [PSEL_W-1:0] psel,
  input  logic [MUX_W-1:0]  mux_sel,
  input  logic              cmp_in,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] dac_code,
  output logic              sh_strobe,
  output logic [MUX_W-1:0]  mux_q,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              done_flag
);

  logic rise_tick, fall_tick;
  logic begin_p, samp_p, load_p, step_p, done_p, conv_act;
  logic start_q, done_q, sh_q;
  logic [DATA_W-1:0] res_q;
  logic [MUX_W-1:0]  sel_q;
  logic [DATA_W-1:0] sar_code;

  adc_presc #(
    .SEL_W (PSEL_W)
  ) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .psel      (psel),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  adc_seq_fsm #(
    .NBITS   (DATA_W),
    .SAMP_AT (SAMPLE_CYC),
    .WARMUP  (WARMUP_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .start_bit (start_q),
    .begin_p   (begin_p),
    .samp_p    (samp_p),
    .load_p    (load_p),
    .step_p    (step_p),
    .done_p    (done_p),
    .conv_act  (conv_act)
  );

  adc_sar #(
    .WIDTH (DATA_W)
  ) u_sar (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!en || begin_p),
    .load   (load_p),
    .step   (step_p),
    .cmp_in (cmp_in),
    .code   (sar_code)
  );

  // start bit: completion and disable both win over a new request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       start_q <= 1'b0;
    else if (!en)     start_q <= 1'b0;
    else if (done_p)  start_q <= 1'b0;
    else if (start)   start_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (done_p)   done_q <= 1'b1;
    else if (flag_clr) done_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      sel_q <= '0;
      sh_q  <= 1'b0;
    end else begin
      sh_q <= samp_p;
      if (done_p)  res_q <= sar_code;
      if (begin_p) sel_q <= mux_sel;
    end
  end

  assign dac_code  = sar_code;
  assign sh_strobe = sh_q;
  assign mux_q     = sel_q;
  assign busy      = start_q;
  assign result    = res_q;
  assign done_flag = done_q;

  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(busy)); // R9

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy); // R11

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sh_strobe |=> !sh_strobe); // R6

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag); // R10

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_act && $past(conv_act)) |-> $stable(mux_q)); // R7

endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

  localparam int DW = 10;
  localparam int MW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          start = 1'b0;
  logic          flag_clr = 1'b0;
  logic [2:0]    psel = 3'd0;
  logic [MW-1:0] mux_sel = '0;
  logic [DW-1:0] vin = '0;
  logic          cmp_in;
  logic [DW-1:0] dac_code;
  logic          sh_strobe;
  logic [MW-1:0] mux_q;
  logic          busy;
  logic [DW-1:0] result;
  logic          done_flag;

  adc_seq_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .start     (start),
    .psel      (psel),
    .mux_sel   (mux_sel),
    .cmp_in    (cmp_in),
    .flag_clr  (flag_clr),
    .dac_code  (dac_code),
    .sh_strobe (sh_strobe),
    .mux_q     (mux_q),
    .busy      (busy),
    .result    (result),
    .done_flag (done_flag)
  );

  always #10 clk = ~clk;

  // comparator model: trial code not above the input keeps the bit
  assign cmp_in = (dac_code <= vin);

  int tcount = 0;
  always @(posedge clk) tcount <= tcount + 1;

  int n_vec = 0;
  int n_bad = 0;
  logic [DW+MW-1:0] exp_q[$];
  logic [DW+MW-1:0] mon_e;
  int done_cnt = 0;
  int d_edge = 0;
  int st_edge = 0;
  int strb_cnt = 0;
  logic prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ndiv(input logic [2:0] p);
    return (p == 3'd0) ? 2 : (1 << p);
  endfunction

  // monitor: scoreboard pop on each rising done flag
  always @(negedge clk) begin
    if (sh_strobe) begin
      strb_cnt++;
      st_edge = tcount;
    end
    if (rst_n && done_flag && !prev_done) begin
      done_cnt++;
      d_edge = tcount;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 R12 unexpected completion", 1, 0);
      end else begin
        mon_e = exp_q.pop_front();
        chk(result == mon_e[DW-1:0], "R8 result code", int'(result), int'(mon_e[DW-1:0]));
        chk(mux_q == mon_e[DW+MW-1:DW], "R7 latched select", int'(mux_q), int'(mon_e[DW+MW-1:DW]));
        chk(busy == 1'b0, "R9 start bit cleared at completion", int'(busy), 0);
      end
    end
    prev_done = done_flag;
  end

  task automatic run_conv(input logic [DW-1:0] v, input logic [MW-1:0] m, input bit with_en,
                          input bit extra_start, input int lo, input int hi, input string req);
    int s;
    int c0;
    int n;
    int waited;
    bit trial_seen;
    n = ndiv(psel);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    vin = v;
    mux_sel = m;
    exp_q.push_back({m, v});
    c0 = done_cnt;
    strb_cnt = 0;
    trial_seen = 1'b0;
    if (with_en) en = 1'b1;
    start = 1'b1;
    s = tcount + 1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (done_cnt == c0 && waited < 40000) begin
      @(negedge clk);
      waited++;
      if (extra_start && waited == 5) start = 1'b1;
      if (extra_start && waited == 6) start = 1'b0;
      if (strb_cnt > 0 && mux_sel == m) mux_sel = ~m;
      if (strb_cnt > 0 && !trial_seen && tcount == st_edge + n / 2) begin
        trial_seen = 1'b1;
        chk(dac_code == 10'h200, "R8 MSB trial after sampling", int'(dac_code), 512);
      end
    end
    chk((d_edge - s >= lo) && (d_edge - s <= hi), req, d_edge - s, lo);
    chk(d_edge - st_edge == (23 * n) / 2, "R6 strobe to completion spacing", d_edge - st_edge, (23 * n) / 2);
    chk(strb_cnt == 1, "R6 one strobe per conversion", strb_cnt, 1);
    chk(trial_seen, "R8 trial code observed", int'(trial_seen), 1);
  endtask

  task automatic normal(input logic [DW-1:0] v, input logic [MW-1:0] m);
    int n;
    n = ndiv(psel);
    run_conv(v, m, 1'b0, 1'b0, 13 * n + 1, 14 * n, "R4 normal conversion length");
  endtask

  task automatic first_at(input logic [2:0] p, input logic [DW-1:0] v, input logic [MW-1:0] m);
    @(negedge clk);
    en = 1'b0;
    psel = p;
    repeat (3) @(negedge clk);
    run_conv(v, m, 1'b1, 1'b0, 26 * ndiv(p) - 1, 26 * ndiv(p) - 1, "R2 R5 first conversion exact length");
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R4: actual hang expected completion");
    summary();
    $finish;
  end

  initial begin
    int c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(done_flag == 1'b0, "R1 done after reset", int'(done_flag), 0);
    chk(sh_strobe == 1'b0, "R1 strobe after reset", int'(sh_strobe), 0);
    chk(dac_code == '0, "R1 dac code after reset", int'(dac_code), 0);
    chk(result == '0, "R1 result after reset", int'(result), 0);
    chk(mux_q == '0, "R1 select after reset", int'(mux_q), 0);

    // R3: start while disabled is ignored
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R3 start ignored while disabled", int'(busy), 0);
    strb_cnt = 0;
    en = 1'b1;
    repeat (60) @(negedge clk);
    chk(busy == 1'b0, "R3 no pending start after enable", int'(busy), 0);
    chk(done_cnt == 0, "R3 no completion from ignored start", done_cnt, 0);
    chk(strb_cnt == 0, "R3 no strobe from ignored start", strb_cnt, 0);

    // R2 R5: first conversion at divide-by-2
    first_at(3'd0, 10'h2AA, 4'd3);

    // R10: flag held until cleared
    repeat (40) @(negedge clk);
    chk(done_flag == 1'b1, "R10 flag held without clear", int'(done_flag), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(done_flag == 1'b0, "R10 flag cleared by pulse", int'(done_flag), 0);

    // R4 R8: several input values at divide-by-2
    normal(10'h000, 4'd1);
    normal(10'h3FF, 4'd2);
    normal(10'h200, 4'd4);
    normal(10'h1FF, 4'd5);
    normal(10'h155, 4'd6);

    // R12: second start while busy
    c = done_cnt;
    run_conv(10'h0F0, 4'd7, 1'b0, 1'b1, 27, 28, "R4 R12 length with extra start");
    repeat (80) @(negedge clk);
    chk(done_cnt == c + 1, "R12 single completion", done_cnt - c, 1);
    chk(busy == 1'b0, "R12 no queued start", int'(busy), 0);

    // R11: abort mid-conversion
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    vin = 10'h123;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
    en = 1'b0;
    c = done_cnt;
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy dropped on disable", int'(busy), 0);
    repeat (40) @(negedge clk);
    chk(done_cnt == c, "R11 no completion after abort", done_cnt - c, 0);
    chk(done_flag == 1'b0, "R11 flag stays clear after abort", int'(done_flag), 0);
    run_conv(10'h3C3, 4'd9, 1'b1, 1'b0, 51, 51, "R11 R5 long sequence re-armed");

    // R2: code 1 divides by two as code 0
    first_at(3'd1, 10'h0A5, 4'd10);

    // R2: divide-by-4 and divide-by-8
    first_at(3'd2, 10'h321, 4'd11);
    normal(10'h07F, 4'd12);
    normal(10'h380, 4'd13);
    first_at(3'd3, 10'h2D2, 4'd14);
    normal(10'h001, 4'd15);

    // R2: widest ratio
    first_at(3'd7, 10'h1AB, 4'd8);
    normal(10'h3FE, 4'd0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R9 every expected completion seen", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule